// File: doc/BRIEF.md
# Counter event stream generator

This block watches a free-running 64-bit count value and emits a single-cycle pulse whenever one chosen bit of that count moves in a chosen direction. The chosen bit is named by a 4-bit selector. A scale flag moves the selector's window from the low 16 bits of the count up by eight positions. The pulses form a periodic event stream whose rate software picks by choosing the bit. A wake-up or wait unit downstream of this block consumes the stream.

Software programs the block through a 64-bit control word with a write strobe and a read-back path. Only a handful of bits in that word hold state. A pair of host-mode inputs, both high, mutes the stream no matter what the control word says. Changing the selector or the scale never produces an event of its own. The comparison always uses two samples of the same bit.

Top module: `evstream_gen`

## Requirements
- R1: After synchronous reset the control word reads all zeros and the event output is 0.
- R2: A write stores bit 2 (enable), bit 3 (direction), bits [7:4] (selector) and bit 17 (scale) of the write data. These are visible on the read port from the cycle after the write. All other bits read 0 and ignore written values, so reading after writing all ones gives 0x0000_0000_0002_00FC.
- R3: With scale 0 the trigger is count bit number selector (0 to 15). Transitions of other bits produce no event.
- R4: With scale 1 the trigger is count bit number selector+8 (8 to 23). Transitions of the bit that scale 0 would select produce no event.
- R5: With direction 0 an event fires when the trigger bit goes from 0 to 1. With direction 1 it fires when the bit goes from 1 to 0. The opposite transition never fires.
- R6: With enable 0 no event is produced, whatever the count does.
- R7: When both host-mode inputs are 1, no event is produced. When only one of them is 1, events behave as if neither were set.
- R8: The event is high for exactly one clock. It is high in the cycle after the clock edge at which the count first shows the qualifying new bit value.
- R9: Changing the selector or the scale never creates an event by itself. The first comparison after a write is between the newly selected bit as sampled at the write edge and the same bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_i | input | 64 | Free-running count value |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 64 | Control word write data |
| cfg_rdata_o | output | 64 | Control word read-back |
| hv_host_i | input | 1 | Host-mode condition, first half |
| hv_route_i | input | 1 | Host-mode condition, second half |
| evt_o | output | 1 | One-cycle event pulse |

## Verification
Two bad internal states can arise. One is a stale previous-bit register, which shows as an extra pulse or a missing pulse one cycle after the selector or scale is rewritten. The other is a wrong bit index, which shows within one period of the intended bit as pulses at the wrong rate or none at all. A pulse that is late, doubled or of the wrong polarity shows in the very next cycle. That is because the stream is compared cycle by cycle against a model that tracks the expected previous bit itself. A stored control field that is corrupted shows at once on the read port, and the bench reads it back after every write.

// File: rtl/evs_pkg.sv
package evs_pkg;
    localparam int CFG_W     = 64;
    localparam int SEL_W     = 4;
    localparam int EN_POS    = 2;
    localparam int DIR_POS   = 3;
    localparam int SEL_LSB   = 4;
    localparam int SCALE_POS = 17;

    typedef struct packed {
        logic             scale;
        logic [SEL_W-1:0] sel;
        logic             dir;
        logic             en;
    } evs_cfg_t;

    function automatic logic [CFG_W-1:0] cfg_to_word(input evs_cfg_t c);
        logic [CFG_W-1:0] w;
        w                        = '0;
        w[EN_POS]                = c.en;
        w[DIR_POS]               = c.dir;
        w[SEL_LSB +: SEL_W]      = c.sel;
        w[SCALE_POS]             = c.scale;
        return w;
    endfunction

    function automatic evs_cfg_t word_to_cfg(input logic [CFG_W-1:0] w);
        evs_cfg_t c;
        c.en    = w[EN_POS];
        c.dir   = w[DIR_POS];
        c.sel   = w[SEL_LSB +: SEL_W];
        c.scale = w[SCALE_POS];
        return c;
    endfunction

    localparam logic [CFG_W-1:0] CFG_MASK = cfg_to_word('{scale: 1'b1, sel: '1, dir: 1'b1, en: 1'b1});
endpackage

// File: rtl/evs_ctrl_reg.sv
module evs_ctrl_reg
    import evs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output evs_cfg_t         cfg_q_o,
    output evs_cfg_t         cfg_d_o,
    output logic [CFG_W-1:0] rdata_o
);
    typedef struct packed {
        evs_cfg_t cfg;
    } state_t;

    state_t s_d, s_q;
    logic   unused_wbits;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            s_d.cfg = word_to_cfg(wdata_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_q_o      = s_q.cfg;
    assign cfg_d_o      = s_d.cfg;
    assign rdata_o      = cfg_to_word(s_q.cfg);
    assign unused_wbits = ^(wdata_i & ~CFG_MASK);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdata_o == '0)); // R1
    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (rdata_o == ($past(wdata_i) & CFG_MASK))); // R2
endmodule

// File: rtl/evs_bit_pick.sv
module evs_bit_pick #(
    parameter int CNT_W = 64,
    parameter int SEL_W = 4,
    parameter int SHIFT = 8
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             scale_i,
    output logic             bit_o
);
    localparam int NSEL = 1 << SEL_W;
    localparam int TOP  = NSEL + SHIFT;

    logic [NSEL-1:0] cand;

    for (genvar i = 0; i < NSEL; i++) begin : g_cand
        assign cand[i] = scale_i ? cnt_i[i + SHIFT] : cnt_i[i];
    end

    assign bit_o = cand[sel_i];

    if (TOP < CNT_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^cnt_i[CNT_W-1:TOP];
    end
endmodule

// File: rtl/evs_edge.sv
module evs_edge (
    input  logic clk,
    input  logic rst,
    input  logic cur_i,
    input  logic nxt_i,
    input  logic dir_i,
    input  logic en_i,
    input  logic mute_i,
    output logic evt_o
);
    typedef struct packed {
        logic prev;
        logic evt;
    } state_t;

    state_t s_d, s_q;
    logic   rise, fall;

    always_comb begin
        rise      = ~s_q.prev & cur_i;
        fall      = s_q.prev & ~cur_i;
        s_d.prev  = nxt_i;
        s_d.evt   = en_i & ~mute_i & (dir_i ? fall : rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign evt_o = s_q.evt;

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !evt_o); // R6
    AST_HOST_SILENT: assert property (@(posedge clk) disable iff (rst)
        mute_i |=> !evt_o); // R7
    AST_RISE_FIRES: assert property (@(posedge clk) disable iff (rst)
        (en_i && !mute_i && !dir_i && !s_q.prev && cur_i) |=> evt_o); // R5
    AST_FALL_FIRES: assert property (@(posedge clk) disable iff (rst)
        (en_i && !mute_i && dir_i && s_q.prev && !cur_i) |=> evt_o); // R5
    AST_NO_STILL_EVENT: assert property (@(posedge clk) disable iff (rst)
        (s_q.prev == cur_i) |=> !evt_o); // R8
endmodule

// File: rtl/evstream_gen.sv
module evstream_gen
    import evs_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  logic             hv_host_i,
    input  logic             hv_route_i,
    output logic             evt_o
);
    evs_cfg_t cfg_q, cfg_d;
    logic     bit_cur, bit_nxt, mute;

    evs_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_q_o (cfg_q),
        .cfg_d_o (cfg_d),
        .rdata_o (cfg_rdata_o)
    );

    evs_bit_pick #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SHIFT(SHIFT)) u_pick_cur (
        .cnt_i   (cnt_i),
        .sel_i   (cfg_q.sel),
        .scale_i (cfg_q.scale),
        .bit_o   (bit_cur)
    );

    evs_bit_pick #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SHIFT(SHIFT)) u_pick_nxt (
        .cnt_i   (cnt_i),
        .sel_i   (cfg_d.sel),
        .scale_i (cfg_d.scale),
        .bit_o   (bit_nxt)
    );

    assign mute = hv_host_i & hv_route_i;

    evs_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (bit_cur),
        .nxt_i  (bit_nxt),
        .dir_i  (cfg_q.dir),
        .en_i   (cfg_q.en),
        .mute_i (mute),
        .evt_o  (evt_o)
    );
endmodule

// File: tb/evstream_gen_test.sv
module evstream_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cnt = '0;
    logic        we = 1'b0;
    logic [63:0] wd = '0;
    logic [63:0] rd;
    logic        h1 = 1'b0, h2 = 1'b0;
    logic        evt;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct { logic e; string tag; } exp_t;
    exp_t q[$];

    logic [63:0] m_cfg  = '0;
    logic        m_prev = 1'b0;
    localparam logic [63:0] MASK = 64'h0000_0000_0002_00FC;

    always #2 clk = ~clk;

    evstream_gen uut (
        .clk(clk), .rst(rst), .cnt_i(cnt), .cfg_we_i(we), .cfg_wdata_i(wd),
        .cfg_rdata_o(rd), .hv_host_i(h1), .hv_route_i(h2), .evt_o(evt)
    );

    function automatic int idx_of(input logic [63:0] c);
        return int'(c[7:4]) + (c[17] ? 8 : 0);
    endfunction

    function automatic logic [63:0] mk(input logic en, input logic dir,
                                       input int sel, input logic sc);
        logic [63:0] w;
        w = '0; w[2] = en; w[3] = dir; w[7:4] = sel[3:0]; w[17] = sc;
        return w;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s evt actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_rd(input logic [63:0] exp, input string tag);
        checks++;
        if (rd !== exp) begin
            errors++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, rd, exp);
        end
    endtask

    task automatic step(input logic [63:0] c, input logic w, input logic [63:0] d,
                        input logic a, input logic b, input string tag);
        exp_t it;
        logic cur;
        @(negedge clk);
        cnt = c; we = w; wd = d; h1 = a; h2 = b;
        cur = c[idx_of(m_cfg)];
        it.e = m_cfg[2] && !(a && b) && (m_cfg[3] ? (m_prev && !cur) : (!m_prev && cur));
        it.tag = tag;
        q.push_back(it);
        if (w) m_cfg = d & MASK;
        m_prev = c[idx_of(m_cfg)];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cnt = '0; we = 1'b0; h1 = 0; h2 = 0;
        q.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cfg = '0; m_prev = 1'b0;
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            check(evt, it.e, it.tag);
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

    initial begin
        logic [63:0] c;
        do_reset();
        // R1: reset state
        chk_rd(64'h0, "R1");
        check(evt, 1'b0, "R1");

        // R2: field storage and reserved bits
        step(0, 1, '1, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        chk_rd(MASK, "R2");
        step(0, 1, 64'h5555_5555_5555_55A4, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        chk_rd(64'h0000_0000_0000_00A4, "R2");
        do_reset();

        // R3 / R5 / R8: scale 0, bit 3, rising then falling
        c = 0;
        step(c, 1, mk(1, 0, 3, 0), 0, 0, "R3");
        step(0, 0, 0, 0, 0, "R2");
        chk_rd(mk(1, 0, 3, 0), "R2");
        for (int i = 0; i < 48; i++) begin c++; step(c, 0, 0, 0, 0, "R3_R8_rise"); end
        step(c, 1, mk(1, 1, 3, 0), 0, 0, "R5");
        for (int i = 0; i < 48; i++) begin c++; step(c, 0, 0, 0, 0, "R5_fall"); end
        // R3: toggling a non-selected bit gives nothing
        for (int i = 0; i < 10; i++) step((i % 2) ? 64'h4 : 64'h0, 0, 0, 0, 0, "R3_other");

        // R4: scale 1, sel 2 -> bit 10
        step(0, 1, mk(1, 0, 2, 1), 0, 0, "R4");
        step(0, 0, 0, 0, 0, "R2");
        chk_rd(mk(1, 0, 2, 1), "R2");
        for (int i = 0; i < 10; i++) step((i % 2) ? 64'h4 : 64'h0, 0, 0, 0, 0, "R4_lowbit");
        c = 0;
        for (int i = 0; i < 40; i++) begin c += 128; step(c, 0, 0, 0, 0, "R4_bit10"); end
        step(0, 1, mk(1, 1, 15, 1), 0, 0, "R4");
        for (int i = 0; i < 10; i++) step((i % 2) ? 64'h80_0000 : 64'h0, 0, 0, 0, 0, "R4_bit23");

        // R6: enable off
        step(0, 1, mk(0, 0, 0, 0), 0, 0, "R6");
        for (int i = 0; i < 12; i++) step(i, 0, 0, 0, 0, "R6");

        // R7: host mute vs single input
        step(0, 1, mk(1, 0, 0, 0), 0, 0, "R7");
        for (int i = 0; i < 12; i++) step(i, 0, 0, 1, 1, "R7_both");
        for (int i = 0; i < 12; i++) step(i, 0, 0, 1, 0, "R7_host_only");
        for (int i = 0; i < 12; i++) step(i, 0, 0, 0, 1, "R7_route_only");

        // R9: reselect between bits of differing value, no spurious event
        step(64'h20, 1, mk(1, 0, 3, 0), 0, 0, "R9");
        step(64'h20, 0, 0, 0, 0, "R9");
        step(64'h20, 1, mk(1, 0, 5, 0), 0, 0, "R9_sel");
        step(64'h20, 0, 0, 0, 0, "R9_sel");
        step(64'h00, 1, mk(1, 1, 13, 0), 0, 0, "R9_dir");
        step(64'h00, 0, 0, 0, 0, "R9");
        step(64'h2000, 1, mk(1, 1, 5, 1), 0, 0, "R9_scale");
        step(64'h2000, 0, 0, 0, 0, "R9_scale");
        step(64'h0000, 0, 0, 0, 0, "R9_after");
        step(64'h0000, 0, 0, 0, 0, "R9_after");
        step(64'h0000, 0, 0, 0, 0, "R9_after");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end
endmodule